// File: doc/BRIEF.md
# Segment Buffer Bulk Invalidation Controller

This block keeps a small array of segment translation entries. Each entry carries a valid flag and a class flag. Software-visible operations reach it through three request ports. A write port loads or overwrites one entry. A single-entry invalidate port clears one valid flag. A bulk invalidate port clears many entries, according to a 3-bit hint taken from the instruction word and to an architecture-mode input.

Every invalidation tells the downstream translation cache to drop its contents by raising a one-cycle flush request. Overwriting an entry does not raise this request. A bulk invalidate walks the array one entry per clock, starting at index 0 or index 1. While it walks, `busy` stays high. When the walk ends, `done` pulses for one cycle. The live valid and class flags are exposed as vectors, so the lookup logic next to the block can read them.

Top module: `seg_inval_ctrl`

## Requirements
- R1: An accepted bulk invalidate raises `flush_req` for exactly one cycle, in the cycle after acceptance, for every mode and hint. This holds even when no entry is cleared.
- R2: With the block idle and no bulk request present, a write sets entry `wr_idx` to (`wr_valid`, `wr_class`) from the next cycle on. A write never raises `flush_req`.
- R3: With the block idle and no bulk request present, a single invalidate clears the valid flag of entry `inv_idx`. It raises `flush_req` in the next cycle whether or not that entry was valid.
- R4: The hint is bits [23:21] of `bulk_insn`, read as an unsigned number. No other bit of `bulk_insn` affects the result.
- R5: When `mode_new` is 0, the hint is ignored. The sweep clears every entry except entry 0, and `hint_err` stays low.
- R6: When `mode_new` is 1, hints 0, 1, 2 and 6 give the same result as R5.
- R7: When `mode_new` is 1, hints 3 and 4 start the sweep at entry 0. Hint 4 clears every entry.
- R8: When `mode_new` is 1 and the hint is 3, only entries whose class flag is 1 are cleared. Entries with class 0 keep their valid flag.
- R9: When `mode_new` is 1 and the hint is 7, no entry changes and `busy` never rises. `done` pulses in the cycle after acceptance.
- R10: When `mode_new` is 1 and the hint is 5, the result is the same as hint 0. `hint_err` pulses for one cycle, in the cycle after acceptance. No other case raises `hint_err`.
- R11: A sweep holds `busy` high for NUM_ENT cycles when it starts at entry 0, and for NUM_ENT-1 cycles when it starts at entry 1. `done` pulses for one cycle, with `busy` low, in the cycle right after.
- R12: These requests are dropped without effect: a bulk request that arrives while `busy` is high, and a write or single invalidate that arrives while `busy` is high or in the same cycle as a bulk request. A dropped request changes no entry and raises no flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; all entries become invalid |
| wr_en | input | 1 | Write one entry |
| wr_idx | input | IDX_W | Entry index for the write |
| wr_valid | input | 1 | Valid flag to write |
| wr_class | input | 1 | Class flag to write |
| inv_en | input | 1 | Invalidate one entry |
| inv_idx | input | IDX_W | Entry index for the single invalidate |
| bulk_req | input | 1 | Start a bulk invalidate |
| bulk_insn | input | 32 | Instruction word; the hint is bits [23:21] |
| mode_new | input | 1 | 0 = legacy rules, 1 = newer rules |
| ent_valid | output | NUM_ENT | Valid flag of each entry |
| ent_class | output | NUM_ENT | Class flag of each entry |
| flush_req | output | 1 | One-cycle translation-cache flush request |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle pulse when a bulk invalidate completes |
| hint_err | output | 1 | One-cycle pulse on the undefined hint |

## Verification
The bench runs every mode and hint against several valid and class patterns. It looks for four kinds of fault:
- A design that does not spare entry 0 would clear the low bit under legacy rules.
- A design that gets the class rule backwards would clear the wrong entries under hint 3.
- A design that flushes only when it removes a valid entry would stay silent on hint 7 and on an empty array.
- A design that decodes the hint from the wrong bits would break, because the other bits of the instruction word are set to one.

Separate cases check these points:
- The single invalidate still flushes when its target entry is already invalid.
- A write never flushes.
- A write, single invalidate or bulk request that arrives during a sweep, or a write issued in the same cycle as a bulk request, leaves the array untouched.

// File: rtl/seg_inval_ctrl.sv
module seg_inval_ctrl #(
  parameter int NUM_ENT = 32,
  localparam int IDX_W = $clog2(NUM_ENT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic               wr_valid,
  input  logic               wr_class,
  input  logic               inv_en,
  input  logic [IDX_W-1:0]   inv_idx,
  input  logic               bulk_req,
  input  logic [31:0]        bulk_insn,
  input  logic               mode_new,
  output logic [NUM_ENT-1:0] ent_valid,
  output logic [NUM_ENT-1:0] ent_class,
  output logic               flush_req,
  output logic               busy,
  output logic               done,
  output logic               hint_err
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_ENT - 1);

  logic [NUM_ENT-1:0] vld_q, cls_q;
  logic [IDX_W-1:0]   ptr_q;
  logic               busy_q, cls_only_q, flush_q, done_q, err_q;
  logic [2:0]         hint;
  logic               accept, idle_ok, from_zero, keep_all, by_class, bad_hint;

  assign hint      = bulk_insn[23:21];
  assign accept    = bulk_req && !busy_q;
  assign idle_ok   = !busy_q && !bulk_req;
  assign from_zero = mode_new && (hint == 3'd3 || hint == 3'd4);
  assign by_class  = mode_new && (hint == 3'd3);
  assign keep_all  = mode_new && (hint == 3'd7);
  assign bad_hint  = mode_new && (hint == 3'd5);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q      <= '0;
      cls_q      <= '0;
      ptr_q      <= '0;
      busy_q     <= 1'b0;
      cls_only_q <= 1'b0;
      flush_q    <= 1'b0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      flush_q <= accept || (idle_ok && inv_en);
      err_q   <= accept && bad_hint;
      done_q  <= 1'b0;
      if (accept) begin
        if (keep_all) begin
          done_q <= 1'b1;
        end else begin
          busy_q     <= 1'b1;
          ptr_q      <= from_zero ? '0 : IDX_W'(1);
          cls_only_q <= by_class;
        end
      end else if (busy_q) begin
        if (vld_q[ptr_q] && (!cls_only_q || cls_q[ptr_q]))
          vld_q[ptr_q] <= 1'b0;
        if (ptr_q == LAST) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          ptr_q <= ptr_q + 1'b1;
        end
      end else begin
        if (wr_en && int'(wr_idx) < NUM_ENT) begin
          vld_q[wr_idx] <= wr_valid;
          cls_q[wr_idx] <= wr_class;
        end
        if (inv_en && int'(inv_idx) < NUM_ENT)
          vld_q[inv_idx] <= 1'b0;
      end
    end
  end

  assign ent_valid = vld_q;
  assign ent_class = cls_q;
  assign flush_req = flush_q;
  assign busy      = busy_q;
  assign done      = done_q;
  assign hint_err  = err_q;
endmodule

// File: rtl/seg_inval_ctrl_chk.sv
module seg_inval_ctrl_chk #(
  parameter int NUM_ENT = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               inv_en,
  input logic               bulk_req,
  input logic [31:0]        bulk_insn,
  input logic               mode_new,
  input logic [NUM_ENT-1:0] ent_valid,
  input logic               flush_req,
  input logic               busy,
  input logic               done,
  input logic               hint_err
);
  assert_flush_on_bulk_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bulk_req && !busy) |=> flush_req);

  assert_no_stray_flush_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!(bulk_req && !busy) && !(inv_en && !busy)) |=> !flush_req);

  assert_inv_flush_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_en && !busy && !bulk_req) |=> flush_req);

  assert_skip_sweep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bulk_req && !busy && mode_new && bulk_insn[23:21] == 3'd7) |=> (done && !busy && $stable(ent_valid)));

  assert_err_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bulk_req && !busy) |=> (hint_err == $past(mode_new && bulk_insn[23:21] == 3'd5)));

  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_not_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_no_set_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ((ent_valid & ~$past(ent_valid)) == '0));
endmodule

bind seg_inval_ctrl seg_inval_ctrl_chk #(.NUM_ENT(NUM_ENT)) u_chk (
  .clk(clk), .rst_n(rst_n), .inv_en(inv_en), .bulk_req(bulk_req),
  .bulk_insn(bulk_insn), .mode_new(mode_new), .ent_valid(ent_valid),
  .flush_req(flush_req), .busy(busy), .done(done), .hint_err(hint_err)
);

// File: tb/test_seg_inval_ctrl.sv
`timescale 1ns/1ps
module test_seg_inval_ctrl;
  localparam int N = 8;
  localparam int IW = $clog2(N);

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, wr_valid = 0, wr_class = 0, inv_en = 0, bulk_req = 0, mode_new = 0;
  logic [IW-1:0] wr_idx = '0, inv_idx = '0;
  logic [31:0] bulk_insn = '0;
  logic [N-1:0] ent_valid, ent_class;
  logic flush_req, busy, done, hint_err;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  seg_inval_ctrl #(.NUM_ENT(N)) i_seg_inval_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid),
    .wr_class(wr_class), .inv_en(inv_en), .inv_idx(inv_idx), .bulk_req(bulk_req),
    .bulk_insn(bulk_insn), .mode_new(mode_new), .ent_valid(ent_valid),
    .ent_class(ent_class), .flush_req(flush_req), .busy(busy), .done(done),
    .hint_err(hint_err)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load(logic [N-1:0] pv, logic [N-1:0] pc);
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      if (i > 0) chk("R2 write no flush", flush_req, 0);
      wr_en = 1; wr_idx = IW'(i); wr_valid = pv[i]; wr_class = pc[i];
    end
    @(negedge clk);
    wr_en = 0;
    chk("R2 write no flush", flush_req, 0);
    chk("R2 valid loaded", ent_valid, pv);
    chk("R2 class loaded", ent_class, pc);
  endtask

  function automatic logic [N-1:0] expect_vld(bit m, int h, logic [N-1:0] pv, logic [N-1:0] pc);
    int st = (m && (h == 3 || h == 4)) ? 0 : 1;
    logic [N-1:0] r = pv;
    if (m && h == 7) return pv;
    for (int i = st; i < N; i++)
      if (!(m && h == 3) || pc[i]) r[i] = 1'b0;
    return r;
  endfunction

  task automatic bulk(bit m, int h, logic [N-1:0] pv, logic [N-1:0] pc);
    int cnt = 0;
    int exp_cnt = (m && h == 7) ? 0 : ((m && (h == 3 || h == 4)) ? N : N - 1);
    @(negedge clk);
    bulk_req = 1; mode_new = m;
    bulk_insn = 32'hFF1F_FFFF | (32'(h) << 21);
    @(negedge clk);
    bulk_req = 0;
    chk("R1 flush after bulk", flush_req, 1);
    chk("R10 hint_err", hint_err, (m && h == 5) ? 1 : 0);
    while (busy && cnt < 100) begin
      cnt++;
      @(negedge clk);
    end
    chk("R11 busy cycles", cnt, exp_cnt);
    chk("R11 done pulse", done, 1);
    chk(m ? "R4 R6 R7 R8 R9 R10 result" : "R5 legacy result", ent_valid, expect_vld(m, h, pv, pc));
    @(negedge clk);
    chk("R11 done one cycle", done, 0);
    chk("R1 flush one cycle", flush_req, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] pvs [5] = '{8'hFF, 8'hA5, 8'h00, 8'h5A, 8'h81};
    logic [N-1:0] pcs [5] = '{8'h0F, 8'h33, 8'hFF, 8'hC6, 8'h01};
    repeat (3) @(negedge clk);
    chk("R2 reset valid", ent_valid, 0);
    chk("R11 reset busy", busy, 0);
    chk("R11 reset done", done, 0);
    chk("R1 reset flush", flush_req, 0);
    rst_n = 1;

    for (int m = 0; m < 2; m++)
      for (int h = 0; h < 8; h++)
        for (int p = 0; p < 5; p++) begin
          load(pvs[p], pcs[p]);
          bulk(m[0], h, pvs[p], pcs[p]);
        end

    // R3: invalidate already-invalid entry still flushes
    load(8'hFB, 8'h00);
    @(negedge clk); inv_en = 1; inv_idx = 3'd2;
    @(negedge clk); inv_en = 0;
    chk("R3 flush on invalid target", flush_req, 1);
    chk("R3 vector unchanged", ent_valid, 8'hFB);
    @(negedge clk); inv_en = 1; inv_idx = 3'd0;
    @(negedge clk); inv_en = 0;
    chk("R3 flush on valid target", flush_req, 1);
    chk("R3 entry cleared", ent_valid, 8'hFA);

    // R2: overwrite valid entry, no flush
    @(negedge clk); wr_en = 1; wr_idx = 3'd1; wr_valid = 1; wr_class = 1;
    @(negedge clk); wr_en = 0;
    chk("R2 overwrite no flush", flush_req, 0);
    chk("R2 overwrite class", ent_class, 8'h02);

    // R12: requests during sweep dropped
    load(8'hFF, 8'h00);
    @(negedge clk); bulk_req = 1; mode_new = 1; bulk_insn = 32'h0060_0000;
    @(negedge clk); bulk_req = 0;
    @(negedge clk);
    bulk_req = 1; bulk_insn = 32'h0080_0000;
    wr_en = 1; wr_idx = 3'd5; wr_valid = 0;
    inv_en = 1; inv_idx = 3'd6;
    @(negedge clk);
    bulk_req = 0; wr_en = 0; inv_en = 0;
    chk("R12 no flush from dropped requests", flush_req, 0);
    while (busy) @(negedge clk);
    chk("R12 done after original sweep", done, 1);
    chk("R12 R8 vector intact", ent_valid, 8'hFF);

    // R12: write in same cycle as bulk dropped (hint 7 keeps array)
    @(negedge clk);
    bulk_req = 1; mode_new = 1; bulk_insn = 32'h00E0_0000;
    wr_en = 1; wr_idx = 3'd4; wr_valid = 0;
    @(negedge clk);
    bulk_req = 0; wr_en = 0;
    chk("R12 R9 same-cycle write dropped", ent_valid, 8'hFF);
    chk("R9 done no sweep", done, 1);

    repeat (2) @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule